// File: doc/BRIEF.md
# Packed SIMD Integer Adder

This block adds or subtracts two 64-bit words that hold packed integers. The lane width is picked at run time for each operation: eight lanes of 8 bits, four of 16, two of 32, or a single 64-bit lane. The same operation is applied to all lanes in the same cycle, and no carry or borrow crosses from one lane into the next. Each lane's result can wrap, or it can be clamped to the signed or unsigned range of that lane.

The carry path is built from 8-bit segments. At every segment boundary a multiplexer chooses between the carry from the segment below and the lane's own carry-in. The carry-in is the subtract bit, because a subtraction is done as the first operand plus the inverted second operand plus one. The saturation stage reads the top segment of each lane and decides whether that lane is clamped. Its result goes into one output register.

Both ends of the block are valid/ready streams. A beat is accepted when `in_valid` and `in_ready` are both high on a rising edge. Its result appears in the next cycle with `out_valid` high. While `out_valid` is high and `out_ready` is low, the result is held unchanged and `in_ready` stays low, so no beat can be accepted. When `out_ready` is high, the held result is drained and a new beat can be accepted in that same cycle.

Top module: `packed_simd_adder`

## Requirements
- R1: `in_lane_size` selects the lane width as follows: 0 gives 8-bit lanes, 1 gives 16-bit, 2 gives 32-bit and 3 gives one 64-bit lane. Lane k takes bits [k*L+L-1 : k*L] of each operand. In wrap mode with `in_sub`=0, each lane gives (a+b) mod 2^L and takes no carry from the lane below.
- R2: With `in_sub`=1, each lane gives (a-b) mod 2^L in wrap mode, and no borrow passes between lanes.
- R3: `in_sat_mode`=1 selects signed saturation. Each lane result is the exact signed sum or difference, clamped to the range [-2^(L-1), 2^(L-1)-1].
- R4: `in_sat_mode`=2 selects unsigned saturation. An addition that overflows gives all ones, and a subtraction with a < b gives 0.
- R5: `in_sat_mode` values 0 and 3 both select wrap mode. Each lane keeps only its low L bits.
- R6: For the 64-bit lane size, `in_sat_mode` has no effect and the result always wraps.
- R7: A beat accepted on a rising edge appears on `out_data`, with `out_valid` high, one cycle later.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: After reset, `out_valid` is low.
- R10: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. When a result is drained, a new beat can be accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can accept a beat |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| in_lane_size | input | 2 | Lane width: 0=8, 1=16, 2=32, 3=64 bits |
| in_sub | input | 1 | 0 = add, 1 = subtract (a-b) |
| in_sat_mode | input | 2 | 0/3 = wrap, 1 = signed saturation, 2 = unsigned saturation |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | 64 | Packed result |

## Verification
Two functions can act in the same cycle. The first is one lane saturating while its neighbour wraps or stays in range. The second is draining a held result while the next beat is accepted. The sweep covers the first: it pairs corner operands such as 0x80/0x7F/0xFF patterns with random words under every lane size, operation and mode. Each lane is compared with its own arithmetic model, so a clamp that spills into a neighbouring lane shows up as a mismatch in that lane. For the second, the bench stalls the output with a beat pending, then raises `out_ready`. It checks that the held beat stays unchanged while stalled and that the pending beat's result follows in the next cycle.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  localparam int NSEG      = 8;
  localparam int SEG_IDX_W = $clog2(NSEG);

  typedef enum logic [1:0] {
    LS8  = 2'd0,
    LS16 = 2'd1,
    LS32 = 2'd2,
    LS64 = 2'd3
  } lane_size_e;

  typedef enum logic [1:0] {
    SAT_WRAP     = 2'd0,
    SAT_SIGNED   = 2'd1,
    SAT_UNSIGNED = 2'd2,
    SAT_WRAP_ALT = 2'd3
  } sat_mode_e;

  // Low segment-index bits that stay inside one lane
  function automatic logic [SEG_IDX_W-1:0] seg_mask(lane_size_e ls);
    return SEG_IDX_W'((1 << int'(ls)) - 1);
  endfunction
endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder
  import simd_add_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SEG_W*NSEG-1:0] a,
  input  logic [SEG_W*NSEG-1:0] b,
  input  lane_size_e            lane_size,
  input  logic                  sub,
  output logic [SEG_W*NSEG-1:0] sum,
  output logic [NSEG-1:0]       seg_cout
);
  localparam int DW = SEG_W * NSEG;

  logic [DW-1:0]   b_eff;
  logic [NSEG-1:0] lane_start;

  assign b_eff = sub ? ~b : b;

  for (genvar s = 0; s < NSEG; s++) begin : g_start
    assign lane_start[s] = ((SEG_IDX_W'(s) & seg_mask(lane_size)) == '0);
  end

  // Ripple across segments; cut the chain where a new lane begins
  always_comb begin
    logic             c;
    logic [SEG_W:0]   part;
    c        = sub;
    sum      = '0;
    seg_cout = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (lane_start[s]) c = sub;
      part = {1'b0, a[s*SEG_W +: SEG_W]} + {1'b0, b_eff[s*SEG_W +: SEG_W]}
           + (SEG_W+1)'(c);
      sum[s*SEG_W +: SEG_W] = part[SEG_W-1:0];
      seg_cout[s]           = part[SEG_W];
      c                     = part[SEG_W];
    end
  end

  // With the narrowest lanes every segment stands alone
  for (genvar s = 0; s < NSEG; s++) begin : g_chk
    assert_byte_isolated_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_size == LS8 && !sub) |->
        sum[s*SEG_W +: SEG_W] == SEG_W'(a[s*SEG_W +: SEG_W] + b[s*SEG_W +: SEG_W]));
  end
endmodule

// File: rtl/simd_lane_sat.sv
module simd_lane_sat
  import simd_add_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SEG_W*NSEG-1:0] a,
  input  logic [SEG_W*NSEG-1:0] b,
  input  logic [SEG_W*NSEG-1:0] sum,
  input  logic [NSEG-1:0]       seg_cout,
  input  lane_size_e            lane_size,
  input  logic                  sub,
  input  sat_mode_e             mode,
  output logic [SEG_W*NSEG-1:0] data
);
  localparam int DW = SEG_W * NSEG;

  sat_mode_e eff_mode;
  assign eff_mode = (lane_size == LS64) ? SAT_WRAP : mode;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG_IDX_W-1:0] top;
    logic                 is_top;
    logic                 a_sgn, b_sgn, r_sgn, c_top;
    logic                 s_ovf;
    logic [SEG_W-1:0]     seg_out;

    assign top    = SEG_IDX_W'(s) | seg_mask(lane_size);
    assign is_top = (top == SEG_IDX_W'(s));
    assign a_sgn  = a[32'(top)*SEG_W + SEG_W-1];
    assign b_sgn  = b[32'(top)*SEG_W + SEG_W-1] ^ sub;
    assign r_sgn  = sum[32'(top)*SEG_W + SEG_W-1];
    assign c_top  = seg_cout[top];
    assign s_ovf  = (a_sgn == b_sgn) && (r_sgn != a_sgn);

    always_comb begin
      seg_out = sum[s*SEG_W +: SEG_W];
      unique case (eff_mode)
        SAT_SIGNED: begin
          if (s_ovf) begin
            // positive overflow -> max, negative overflow -> min
            if (!a_sgn) seg_out = is_top ? {1'b0, {(SEG_W-1){1'b1}}} : '1;
            else        seg_out = is_top ? {1'b1, {(SEG_W-1){1'b0}}} : '0;
          end
        end
        SAT_UNSIGNED: begin
          if (!sub && c_top)     seg_out = '1;
          else if (sub && !c_top) seg_out = '0;
        end
        default: ;
      endcase
    end

    assign data[s*SEG_W +: SEG_W] = seg_out;

    // A saturating unsigned add never yields less than its first operand
    if (s == NSEG-1) begin : g_usat
      assert_usat_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SAT_UNSIGNED && !sub && lane_size != LS64) |->
          seg_out >= a[s*SEG_W +: SEG_W]);
    end
  end

  logic unused_ok;
  assign unused_ok = ^{DW{1'b0}};
endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [DW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [DW-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

  assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> (dn_valid && dn_data == $past(up_data)));

  assert_reset_idle_R9: assert property (@(posedge clk)
    !rst_n |=> !dn_valid);
endmodule

// File: rtl/packed_simd_adder.sv
module packed_simd_adder
  import simd_add_pkg::*;
#(
  parameter int SEG_W = 8,
  localparam int DW   = SEG_W * NSEG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [1:0]    in_lane_size,
  input  logic          in_sub,
  input  logic [1:0]    in_sat_mode,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  lane_size_e      ls;
  sat_mode_e       sm;
  logic [DW-1:0]   sum_raw;
  logic [NSEG-1:0] seg_cout;
  logic [DW-1:0]   sat_data;

  assign ls = lane_size_e'(in_lane_size);
  assign sm = sat_mode_e'(in_sat_mode);

  simd_seg_adder #(.SEG_W(SEG_W)) u_adder (
    .clk       (clk),
    .rst_n     (rst_n),
    .a         (in_a),
    .b         (in_b),
    .lane_size (ls),
    .sub       (in_sub),
    .sum       (sum_raw),
    .seg_cout  (seg_cout)
  );

  simd_lane_sat #(.SEG_W(SEG_W)) u_sat (
    .clk       (clk),
    .rst_n     (rst_n),
    .a         (in_a),
    .b         (in_b),
    .sum       (sum_raw),
    .seg_cout  (seg_cout),
    .lane_size (ls),
    .sub       (in_sub),
    .mode      (sm),
    .data      (sat_data)
  );

  simd_out_stage #(.DW(DW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (sat_data),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data)
  );

  assert_wrap_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sm == SAT_WRAP || sm == SAT_WRAP_ALT) |-> sat_data == sum_raw);

  assert_wide_lane_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ls == LS64) |-> sat_data == sum_raw);

  assert_ready_rule_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));
endmodule

// File: tb/packed_simd_adder_tb.sv
module packed_simd_adder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0, in_b = '0;
  logic [1:0]  in_lane_size = '0;
  logic        in_sub = 1'b0;
  logic [1:0]  in_sat_mode = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  packed_simd_adder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_lane_size(in_lane_size), .in_sub(in_sub),
    .in_sat_mode(in_sat_mode), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                        int size, bit sub, int mode);
    int L = 8 << size;
    int n = 64 / L;
    int md = (size == 3) ? 0 : mode;
    logic [66:0] mask = (67'd1 << L) - 67'd1;
    logic [63:0] res = '0;
    for (int i = 0; i < n; i++) begin
      logic [66:0] av, bv, ur;
      logic signed [66:0] sa, sb, sr, mx, mn;
      av = ({3'b0, a} >> (i*L)) & mask;
      bv = ({3'b0, b} >> (i*L)) & mask;
      ur = sub ? av - bv : av + bv;
      if (md == 2) begin
        if (!sub && ur > mask) ur = mask;
        if (sub && av < bv)    ur = '0;
      end else if (md == 1) begin
        sa = av[L-1] ? $signed(av - (67'd1 << L)) : $signed(av);
        sb = bv[L-1] ? $signed(bv - (67'd1 << L)) : $signed(bv);
        sr = sub ? sa - sb : sa + sb;
        mx = (67'sd1 <<< (L-1)) - 67'sd1;
        mn = -(67'sd1 <<< (L-1));
        if (sr > mx) sr = mx;
        if (sr < mn) sr = mn;
        ur = sr;
      end
      res = res | 64'((ur & mask) << (i*L));
    end
    return res;
  endfunction

  function automatic string req_of(int size, bit sub, int mode);
    if (size == 3 && mode != 0) return "R6";
    if (mode == 1) return "R3";
    if (mode == 2) return "R4";
    if (mode == 3) return "R5";
    return sub ? "R2" : "R1";
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [63:0] a, logic [63:0] b, int size, bit sub, int mode);
    @(negedge clk);
    in_a = a; in_b = b; in_lane_size = 2'(size); in_sub = sub;
    in_sat_mode = 2'(mode); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7", {63'd0, out_valid}, 64'd1);
    check(req_of(size, sub, mode), out_data, model(a, b, size, sub, mode));
  endtask

  logic [63:0] corners [6];
  logic [63:0] lfsr = 64'hACE1_2468_BDF1_3579;

  function automatic logic [63:0] step(logic [63:0] x);
    return {x[62:0], x[63] ^ x[62] ^ x[60] ^ x[59]};
  endfunction

  initial begin
    corners[0] = 64'h0;
    corners[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    corners[2] = 64'h8080_8080_8080_8080;
    corners[3] = 64'h7F7F_7F7F_7F7F_7F7F;
    corners[4] = 64'h0101_0101_0101_0101;
    corners[5] = 64'h7FFF_8000_FF00_00FF;

    repeat (3) @(negedge clk);
    check("R9", {63'd0, out_valid}, 64'd0);
    check("R10", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;

    for (int size = 0; size < 4; size++)
      for (int sb = 0; sb < 2; sb++)
        for (int mode = 0; mode < 4; mode++) begin
          for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
              run_op(corners[i], corners[j], size, sb[0], mode);
          for (int k = 0; k < 8; k++) begin
            logic [63:0] ra, rb;
            lfsr = step(step(lfsr)); ra = lfsr;
            lfsr = step(step(step(lfsr))); rb = lfsr ^ {lfsr[31:0], lfsr[63:32]};
            run_op(ra, rb, size, sb[0], mode);
          end
        end

    // Back-pressure: stall with a held beat, then drain while accepting
    @(negedge clk);
    out_ready = 1'b0;
    in_a = 64'h00FF_7F80_0102_FFFE; in_b = 64'h0001_0180_FF02_0003;
    in_lane_size = 2'd0; in_sub = 1'b0; in_sat_mode = 2'd1; in_valid = 1'b1;
    @(negedge clk);
    check("R10", {63'd0, in_ready}, 64'd0);
    check("R7", out_data, model(64'h00FF_7F80_0102_FFFE, 64'h0001_0180_FF02_0003, 0, 0, 1));
    in_a = 64'h1234_5678_9ABC_DEF0; in_b = 64'h0FED_CBA9_8765_4321;
    in_lane_size = 2'd1; in_sub = 1'b1; in_sat_mode = 2'd2;
    repeat (2) @(negedge clk);
    check("R8", {63'd0, out_valid}, 64'd1);
    check("R8", out_data, model(64'h00FF_7F80_0102_FFFE, 64'h0001_0180_FF02_0003, 0, 0, 1));
    out_ready = 1'b1;
    #1;
    check("R10", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", out_data, model(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1, 1, 2));
    @(negedge clk);
    check("R7", {63'd0, out_valid}, 64'd0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule